// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three byte-wide parallel ports, called A, B and C, plus one control register. All of them sit behind a small synchronous bus that has a select, a two-bit register address, a read strobe, a write strobe and separate write and read data buses. A control write does one of two things. It sets up the whole block, meaning the direction of each port section and the stored mode fields. Or it changes one bit of port C and leaves the rest alone. Bit 7 of the written byte decides which.

Every port section is either an input or an output. Port C counts as two nibbles, each with its own direction. An output section drives the value last written into its latch. An input section returns the live pin value when it is read. The handshake and bidirectional mode codes are stored and read back, but the ports always behave as plain input/output. Each port also brings out a per-bit enable vector, so that a tri-state pad can be built around it.

Writes take effect on the rising clock edge. A read is combinational: it shows the state present before any write made in the same cycle.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset, the control register reads 8'h9B, all three output latches are 0, and every output-enable bit is 0, so every section is an input.
- R2: With `sel` and `wr` high, the address picks the target register: 2'b00 writes the whole byte into the port A latch, 2'b01 into the port B latch, 2'b10 into the port C latch, and 2'b11 into the control register. A latch value appears on its `*_out` bus one clock later, whatever the direction of that section.
- R3: A control write with bit 7 = 1 stores the byte and sets the directions, where 1 means input and 0 means output. Bit 4 sets port A, bit 3 sets C[7:4], bit 1 sets port B and bit 0 sets C[3:0]. Each `*_oe` bit is 1 exactly when its section is an output.
- R4: A control write with bit 7 = 1 clears all three output latches to 0.
- R5: A control write with bit 7 = 0 writes bit 0 into port C bit number wdata[3:1]. All other latch bits, the other latches and the control register stay unchanged.
- R6: A bit set/reset command that targets a port C bit in an input nibble has no effect on `pc_out`.
- R7: With `sel` and `rd` high, an output section reads back its latch and an input section reads back its pins, nibble by nibble for port C. Address 2'b11 returns the last stored control byte.
- R8: `rdata` is 0 whenever `sel` and `rd` are not both high.
- R9: Mode fields in bits 6:5 and bit 2 (any value, including the handshake and bidirectional codes) are stored and read back. They do not change how directions or data behave.
- R10: A write strobe while `sel` is low changes no latch, no enable and no control state.
- R11: When `rd` and `wr` are both high in one cycle, `rdata` shows the value from before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Block select |
| addr | input | 2 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A drive enable |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B drive enable |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C drive enable |

## Verification
A read and a write can land in the same cycle. The case that matters most is a read of port C during a bit set/reset or a full setup write, while the pins are also changing. The bench raises both strobes together in its random traffic and also in directed steps. It judges `rdata` against a model state from before the edge, and judges the outputs one edge later against the state after the write. A read taken mid-cycle must therefore never show the effect of the write made in that same cycle.

// File: rtl/ppio_ctrl.sv
module ppio_ctrl #(
  parameter int DW = 8,
  parameter logic [DW-1:0] RST_MODE = 8'h9B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [1:0]    addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  localparam int HW = DW / 2;

  logic [DW-1:0] mode_q, a_q, b_q, c_q;

  wire wr_en = sel & wr;
  wire [2:0] bit_idx = wdata[3:1];
  wire [DW-1:0] c_drv = {{HW{~mode_q[3]}}, {HW{~mode_q[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RST_MODE;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
    end else if (wr_en) begin
      case (addr)
        2'b00: a_q <= wdata;
        2'b01: b_q <= wdata;
        2'b10: c_q <= wdata;
        default: begin
          if (wdata[7]) begin
            mode_q <= wdata;
            a_q    <= '0;
            b_q    <= '0;
            c_q    <= '0;
          end else if (c_drv[bit_idx]) begin
            c_q[bit_idx] <= wdata[0];
          end
        end
      endcase
    end
  end

  assign pa_oe  = {DW{~mode_q[4]}};
  assign pb_oe  = {DW{~mode_q[1]}};
  assign pc_oe  = c_drv;
  assign pa_out = a_q;
  assign pb_out = b_q;
  assign pc_out = c_q;

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (addr)
      2'b00:   rd_mux = mode_q[4] ? pa_in : a_q;
      2'b01:   rd_mux = mode_q[1] ? pb_in : b_q;
      2'b10:   rd_mux = (c_q & c_drv) | (pc_in & ~c_drv);
      default: rd_mux = mode_q;
    endcase
  end

  assign rdata = (sel & rd) ? rd_mux : '0;
endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic [1:0] addr,
  input logic       rd,
  input logic       wr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe
);
  AST_PORT_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 2'b00) |=> pa_out == $past(wdata)); // R2
  AST_OE_WHOLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF)); // R3
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 2'b11 && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)); // R4
  AST_BSR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 2'b11 && !wdata[7]) |=>
      (pa_out == $past(pa_out) && pb_out == $past(pb_out) && pc_oe == $past(pc_oe)
       && $countones(pc_out ^ $past(pc_out)) <= 1)); // R5
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rd) |-> rdata == 8'h00); // R8
  AST_NO_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                      && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))); // R10
endmodule

bind ppio_ctrl ppio_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .rd(rd), .wr(wr),
  .wdata(wdata), .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/ppio_ctrl_tb_top.sv
module ppio_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = '0, pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] m_mode, m_a, m_b, m_c;

  always #10 clk = ~clk;

  ppio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  function automatic logic [7:0] cmask(input logic [7:0] m);
    return {{4{~m[3]}}, {4{~m[0]}}};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'b00:   return m_mode[4] ? pa_in : m_a;
      2'b01:   return m_mode[1] ? pb_in : m_b;
      2'b10:   return (m_c & cmask(m_mode)) | (pc_in & ~cmask(m_mode));
      default: return m_mode;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    logic [23:0] eo, ee;
    eo = {m_a, m_b, m_c};
    ee = {{8{~m_mode[4]}}, {8{~m_mode[1]}}, cmask(m_mode)};
    chk({pa_out, pb_out, pc_out} == eo, tag, {8'h0, pa_out, pb_out, pc_out}, {8'h0, eo});
    chk({pa_oe, pb_oe, pc_oe} == ee, "R3", {8'h0, pa_oe, pb_oe, pc_oe}, {8'h0, ee});
  endtask

  task automatic cyc(input bit s, input bit r, input bit w, input logic [1:0] a,
                     input logic [7:0] d, input string otag);
    logic [7:0] er;
    string rtag;
    @(negedge clk);
    sel = s; rd = r; wr = w; addr = a; wdata = d;
    pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
    #2;
    er = (s && r) ? exp_rd(a) : 8'h00;
    rtag = (s && r && w) ? "R11" : (!(s && r)) ? "R8" : "R7";
    chk(rdata == er, rtag, {24'h0, rdata}, {24'h0, er});
    @(posedge clk);
    #1;
    if (s && w) begin
      case (a)
        2'b00: m_a = d;
        2'b01: m_b = d;
        2'b10: m_c = d;
        default: begin
          if (d[7]) begin
            m_mode = d; m_a = '0; m_b = '0; m_c = '0;
          end else if (cmask(m_mode)[d[3:1]]) begin
            m_c[d[3:1]] = d[0];
          end
        end
      endcase
    end
    sel = 1'b0; rd = 1'b0; wr = 1'b0;
    chk_outs(otag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_mode = 8'h9B; m_a = '0; m_b = '0; m_c = '0;
    #45 rst_n = 1'b1;
    #1;
    chk_outs("R1");
    cyc(1, 1, 0, 2'b11, 8'h00, "R1");

    cyc(1, 0, 1, 2'b11, 8'h80, "R3");
    cyc(1, 0, 1, 2'b00, 8'h5A, "R2");
    cyc(1, 0, 1, 2'b01, 8'hC3, "R2");
    cyc(1, 0, 1, 2'b10, 8'h96, "R2");
    cyc(1, 1, 0, 2'b00, 8'h00, "R7");
    cyc(1, 0, 1, 2'b11, 8'h0A, "R5");
    cyc(1, 0, 1, 2'b11, 8'h0B, "R5");
    cyc(0, 0, 1, 2'b00, 8'hFF, "R10");
    cyc(0, 1, 1, 2'b11, 8'h9B, "R10");
    cyc(1, 0, 1, 2'b11, 8'h88, "R4");
    cyc(1, 0, 1, 2'b11, 8'h0D, "R6");
    cyc(1, 0, 1, 2'b11, 8'h05, "R5");
    cyc(1, 1, 0, 2'b10, 8'h00, "R7");
    cyc(1, 1, 1, 2'b10, 8'h3C, "R11");
    cyc(1, 1, 1, 2'b11, 8'h0F, "R11");
    cyc(1, 1, 1, 2'b11, 8'hE5, "R9");
    cyc(1, 1, 0, 2'b11, 8'h00, "R9");
    cyc(1, 0, 1, 2'b00, 8'h77, "R9");
    cyc(1, 1, 0, 2'b10, 8'h00, "R9");
    cyc(1, 0, 1, 2'b11, 8'hDE, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      bit s, r, w;
      a = 2'($urandom);
      d = 8'($urandom);
      s = ($urandom % 8) != 0;
      r = $urandom % 2;
      w = $urandom % 2;
      if (a == 2'b11 && w && ($urandom % 4) != 0) d[7] = 1'b0;
      cyc(s, r, w, a, d, !s ? "R10" : (a == 2'b11 ? (d[7] ? "R4" : "R5") : "R2"));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule